// File: doc/BRIEF.md
# Shifted-Operand Compare-Negative Flag Unit

This unit handles the flag side of a compare-negative operation. It takes two register operands and a shift type with an immediate amount. It shifts the second operand as the shift fields encode, adds it to the first operand with no carry-in, and keeps only the four condition flags (negative, zero, carry, overflow). The sum itself is not kept.

The unit sits behind a decode stage. That stage supplies the shift fields, the current carry flag and a single condition-pass bit that has already been evaluated. The new flags and a flag-write enable are registered on the rising clock edge. Latency is always one cycle, whatever the operand or flag values. When the condition fails, the stored flags hold their values.

Top module: `cmn_flag_unit`

## Requirements
- R1: Shift type 2'b00 is a logical left shift by the immediate amount. An immediate of 0 passes the second operand through unchanged.
- R2: Shift type 2'b01 is a logical right shift by the immediate amount (1 to 31). An immediate of 0 means a shift of 32, which gives an all-zero shifted operand.
- R3: Shift type 2'b10 is an arithmetic right shift by the immediate amount (1 to 31). An immediate of 0 means a shift of 32, which gives 32 copies of the operand's bit 31.
- R4: Shift type 2'b11 with an immediate from 1 to 31 rotates the second operand right by that amount.
- R5: Shift type 2'b11 with an immediate of 0 is a one-bit rotate right through carry. Bit 31 of the shifted operand is carry_in_i, and bits 30:0 are operand bits 31:1.
- R6: flags_o[3] (N) is bit 31 of the 32-bit sum of op_a_i and the shifted operand. flags_o[2] (Z) is 1 exactly when that sum is zero.
- R7: The addition has a carry-in of 0. flags_o[1] (C) is the unsigned carry out of bit 31. flags_o[0] (V) is 1 when the signed sum falls outside the 32-bit two's-complement range.
- R8: When cond_pass_i is 1 at a rising edge, flags_o shows the flags of the inputs sampled at that edge and flag_we_o is 1 until the next edge. The latency is exactly one cycle for every data and flag value.
- R9: When cond_pass_i is 0 at a rising edge, flags_o keeps its previous value and flag_we_o is 0 until the next edge.
- R10: A synchronous, active-high rst clears flags_o and flag_we_o to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_pass_i | input | 1 | Condition check result; 1 allows the flag update |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand, the one that is shifted |
| shift_type_i | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR/RRX |
| shift_imm_i | input | 5 | Immediate shift amount, modulo 32 |
| carry_in_i | input | 1 | Current carry flag, used only by the rotate through carry |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |
| flag_we_o | output | 1 | Registered flag-write enable |

## Verification
A fault in the shifter or the adder shows at the flag outputs one cycle after the edge that sampled the operation. Zero-amount encodings are the most fragile: shift-by-32 and rotate-through-carry appear only as a wrong C, Z or N on operands chosen so that those bits tell the cases apart. A fault in the hold path shows as flags that change after an edge where the condition failed. Because the unit discards the sum, the bench reads all flags back in the cycle right after every operation and compares them with the previous expected value whenever the condition fails.

// File: rtl/cmn_pkg.sv
package cmn_pkg;

  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/cmn_operand_shifter.sv
module cmn_operand_shifter
  import cmn_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opnd_i,
  input  logic [1:0]         kind_i,
  input  logic [SHAMT_W-1:0] imm_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  shifted_o,
  output logic               rrx_sel_o,
  output logic               full_width_o
);

  localparam int AMT_W = SHAMT_W + 1;

  shift_kind_e        kind;
  logic [AMT_W-1:0]   amt;

  function automatic logic [DATA_W-1:0] f_lsl(input logic [DATA_W-1:0] v,
                                              input logic [AMT_W-1:0] n);
    return v << n;
  endfunction

  function automatic logic [DATA_W-1:0] f_lsr(input logic [DATA_W-1:0] v,
                                              input logic [AMT_W-1:0] n);
    return v >> n;
  endfunction

  function automatic logic [DATA_W-1:0] f_asr(input logic [DATA_W-1:0] v,
                                              input logic [AMT_W-1:0] n);
    return DATA_W'($signed(v) >>> n);
  endfunction

  function automatic logic [DATA_W-1:0] f_ror(input logic [DATA_W-1:0] v,
                                              input logic [AMT_W-1:0] n);
    logic [2*DATA_W-1:0] dbl;
    dbl = {v, v} >> n;
    return dbl[DATA_W-1:0];
  endfunction

  assign kind = shift_kind_e'(kind_i);

  // A zero immediate on a right shift stands for the full width.
  assign full_width_o = (imm_i == '0) && (kind == SHK_LSR || kind == SHK_ASR);
  assign rrx_sel_o    = (imm_i == '0) && (kind == SHK_ROR);
  assign amt          = full_width_o ? AMT_W'(DATA_W) : {1'b0, imm_i};

  always_comb begin
    unique case (kind)
      SHK_LSL: shifted_o = f_lsl(opnd_i, amt);
      SHK_LSR: shifted_o = f_lsr(opnd_i, amt);
      SHK_ASR: shifted_o = f_asr(opnd_i, amt);
      default: shifted_o = rrx_sel_o ? {carry_i, opnd_i[DATA_W-1:1]}
                                     : f_ror(opnd_i, amt);
    endcase
  end

endmodule

// File: rtl/cmn_add_flags.sv
module cmn_add_flags
  import cmn_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output nzcv_t             nzcv_o
);

  logic [DATA_W:0] wide;

  function automatic logic f_ovf(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  // Carry-in fixed at zero.
  assign wide  = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o = wide[DATA_W-1:0];

  assign nzcv_o.n = sum_o[DATA_W-1];
  assign nzcv_o.z = (sum_o == '0);
  assign nzcv_o.c = wide[DATA_W];
  assign nzcv_o.v = f_ovf(a_i[DATA_W-1], b_i[DATA_W-1], sum_o[DATA_W-1]);

endmodule

// File: rtl/cmn_flag_reg.sv
module cmn_flag_reg
  import cmn_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_i,
  input  nzcv_t next_i,
  output nzcv_t flags_o,
  output logic  we_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      we_o    <= 1'b0;
    end else begin
      we_o <= load_i;
      if (load_i) flags_o <= next_i;
    end
  end

endmodule

// File: rtl/cmn_flag_unit.sv
module cmn_flag_unit
  import cmn_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cond_pass_i,
  input  logic [DATA_W-1:0]  op_a_i,
  input  logic [DATA_W-1:0]  op_b_i,
  input  logic [1:0]         shift_type_i,
  input  logic [SHAMT_W-1:0] shift_imm_i,
  input  logic               carry_in_i,
  output logic [3:0]         flags_o,
  output logic               flag_we_o
);

  logic [DATA_W-1:0] shifted_w;
  logic [DATA_W-1:0] sum_w;
  logic              rrx_sel_w;
  logic              full_width_w;
  nzcv_t             nzcv_next_w;
  nzcv_t             nzcv_q;

  cmn_operand_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .opnd_i       (op_b_i),
    .kind_i       (shift_type_i),
    .imm_i        (shift_imm_i),
    .carry_i      (carry_in_i),
    .shifted_o    (shifted_w),
    .rrx_sel_o    (rrx_sel_w),
    .full_width_o (full_width_w)
  );

  cmn_add_flags #(.DATA_W(DATA_W)) u_add (
    .a_i    (op_a_i),
    .b_i    (shifted_w),
    .sum_o  (sum_w),
    .nzcv_o (nzcv_next_w)
  );

  cmn_flag_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (cond_pass_i),
    .next_i  (nzcv_next_w),
    .flags_o (nzcv_q),
    .we_o    (flag_we_o)
  );

  assign flags_o = nzcv_q;

endmodule

// File: rtl/cmn_flag_unit_chk.sv
module cmn_flag_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rst,
  input logic               cond_pass_i,
  input logic [DATA_W-1:0]  op_a_i,
  input logic [DATA_W-1:0]  op_b_i,
  input logic [1:0]         shift_type_i,
  input logic [SHAMT_W-1:0] shift_imm_i,
  input logic               carry_in_i,
  input logic [DATA_W-1:0]  shifted_w,
  input logic [3:0]         nzcv_next_w,
  input logic               rrx_sel_w,
  input logic [3:0]         flags_o,
  input logic               flag_we_o
);

  AST_LSR_FULL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (shift_type_i == 2'b01 && shift_imm_i == '0) |-> (shifted_w == '0)); // R2

  AST_ASR_FULL_SIGN: assert property (@(posedge clk) disable iff (rst)
    (shift_type_i == 2'b10 && shift_imm_i == '0) |-> (shifted_w == {DATA_W{op_b_i[DATA_W-1]}})); // R3

  AST_RRX_CARRY_TOP: assert property (@(posedge clk) disable iff (rst)
    rrx_sel_w |-> (shifted_w == {carry_in_i, op_b_i[DATA_W-1:1]})); // R5

  AST_V_NEEDS_SAME_SIGN: assert property (@(posedge clk) disable iff (rst)
    nzcv_next_w[0] |-> (op_a_i[DATA_W-1] == shifted_w[DATA_W-1])); // R7

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cond_pass_i |=> (flag_we_o && flags_o == $past(nzcv_next_w))); // R8

  AST_HOLD_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    !cond_pass_i |=> (!flag_we_o && $stable(flags_o))); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (flags_o == 4'b0 && !flag_we_o)); // R10

endmodule

bind cmn_flag_unit cmn_flag_unit_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cond_pass_i  (cond_pass_i),
  .op_a_i       (op_a_i),
  .op_b_i       (op_b_i),
  .shift_type_i (shift_type_i),
  .shift_imm_i  (shift_imm_i),
  .carry_in_i   (carry_in_i),
  .shifted_w    (shifted_w),
  .nzcv_next_w  (nzcv_next_w),
  .rrx_sel_w    (rrx_sel_w),
  .flags_o      (flags_o),
  .flag_we_o    (flag_we_o)
);

// File: tb/cmn_flag_unit_tb.sv
`timescale 1ns/1ps
module cmn_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cond_pass_i;
  logic [31:0] op_a_i;
  logic [31:0] op_b_i;
  logic [1:0]  shift_type_i;
  logic [4:0]  shift_imm_i;
  logic        carry_in_i;
  logic [3:0]  flags_o;
  logic        flag_we_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_hold = 4'b0;

  always #4 clk = ~clk;

  cmn_flag_unit u_dut (
    .clk(clk), .rst(rst), .cond_pass_i(cond_pass_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .shift_type_i(shift_type_i),
    .shift_imm_i(shift_imm_i), .carry_in_i(carry_in_i),
    .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  // Bit-by-bit reference shifter.
  function automatic logic [31:0] m_shift(input logic [31:0] b, input logic [1:0] t,
                                          input logic [4:0] imm, input logic c);
    logic [31:0] r;
    int amt;
    r = '0;
    amt = (imm == 0 && (t == 2'b01 || t == 2'b10)) ? 32 : int'(imm);
    for (int i = 0; i < 32; i++) begin
      case (t)
        2'b00: r[i] = (i >= amt) ? b[i-amt] : 1'b0;
        2'b01: r[i] = (i + amt < 32) ? b[i+amt] : 1'b0;
        2'b10: r[i] = (i + amt < 32) ? b[i+amt] : b[31];
        default: r[i] = b[(i + amt) % 32];
      endcase
    end
    if (t == 2'b11 && imm == 0) r = {c, b[31:1]};
    return r;
  endfunction

  function automatic logic [3:0] m_flags(input logic [31:0] a, input logic [31:0] sh);
    longint us, ss;
    logic [31:0] res;
    logic n, z, cy, v;
    us  = longint'({32'b0, a}) + longint'({32'b0, sh});
    ss  = longint'($signed(a)) + longint'($signed(sh));
    res = us[31:0];
    n   = res[31];
    z   = (res == 32'd0);
    cy  = (us >= 64'sh1_0000_0000);
    v   = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    return {n, z, cy, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one operation at negedge and checks at the following negedge.
  task automatic op(input string req, input logic [31:0] a, input logic [31:0] b,
                    input logic [1:0] t, input logic [4:0] imm, input logic c,
                    input logic cp);
    logic [3:0] e;
    @(negedge clk);
    op_a_i = a; op_b_i = b; shift_type_i = t; shift_imm_i = imm;
    carry_in_i = c; cond_pass_i = cp;
    e = cp ? m_flags(a, m_shift(b, t, imm, c)) : exp_hold;
    @(negedge clk);
    check({req, " flags"}, {28'b0, flags_o}, {28'b0, e});
    check({req, " we"}, {31'b0, flag_we_o}, {31'b0, cp});
    exp_hold = e;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    int unsigned seed;
    seed = 32'd7;
    void'($urandom(seed));
    rst = 1'b1; cond_pass_i = 0; op_a_i = 0; op_b_i = 0;
    shift_type_i = 0; shift_imm_i = 0; carry_in_i = 0;
    repeat (2) @(negedge clk);
    check("R10 reset flags", {28'b0, flags_o}, 32'd0);
    check("R10 reset we", {31'b0, flag_we_o}, 32'd0);
    rst = 1'b0;

    op("R1 lsl0 passthru", 32'h1, 32'h8000_0000, 2'b00, 5'd0, 1'b1, 1'b1);
    op("R1 lsl31",         32'h0, 32'h0000_0003, 2'b00, 5'd31, 1'b0, 1'b1);
    op("R2 lsr32 zero",    32'h0, 32'hFFFF_FFFF, 2'b01, 5'd0, 1'b1, 1'b1);
    op("R2 lsr1",          32'h7FFF_FFFF, 32'h0000_0002, 2'b01, 5'd1, 1'b0, 1'b1);
    op("R3 asr32 neg",     32'h1, 32'h8000_0000, 2'b10, 5'd0, 1'b0, 1'b1);
    op("R3 asr32 pos",     32'h5, 32'h7FFF_FFFF, 2'b10, 5'd0, 1'b1, 1'b1);
    op("R3 asr4",          32'h0, 32'hF000_0000, 2'b10, 5'd4, 1'b0, 1'b1);
    op("R4 ror8",          32'h0, 32'h0000_0080, 2'b11, 5'd8, 1'b0, 1'b1);
    op("R5 rrx c1",        32'h0, 32'h0000_0001, 2'b11, 5'd0, 1'b1, 1'b1);
    op("R5 rrx c0",        32'h0, 32'h0000_0001, 2'b11, 5'd0, 1'b0, 1'b1);
    op("R6 zero result",   32'hFFFF_FFFF, 32'h1, 2'b00, 5'd0, 1'b0, 1'b1);
    op("R7 signed ovf",    32'h7FFF_FFFF, 32'h1, 2'b00, 5'd0, 1'b0, 1'b1);
    op("R7 neg ovf",       32'h8000_0000, 32'h8000_0000, 2'b00, 5'd0, 1'b0, 1'b1);
    op("R9 hold",          32'h0, 32'h0, 2'b00, 5'd0, 1'b0, 1'b0);
    op("R9 hold again",    32'h1234_5678, 32'h1, 2'b11, 5'd0, 1'b1, 1'b0);
    op("R8 load",          32'h0, 32'h0, 2'b00, 5'd0, 1'b0, 1'b1);

    for (int k = 0; k < 400; k++) begin
      logic [1:0] t;
      logic [4:0] imm;
      t   = 2'($urandom);
      imm = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      op("R8 random", $urandom, $urandom, t, imm, 1'($urandom),
         ($urandom % 5) != 0);
    end

    // Mid-run reset after non-zero flags.
    op("R7 carry set", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 5'd0, 1'b0, 1'b1);
    @(negedge clk); rst = 1'b1; cond_pass_i = 1'b1;
    @(negedge clk);
    check("R10 mid reset flags", {28'b0, flags_o}, 32'd0);
    check("R10 mid reset we", {31'b0, flag_we_o}, 32'd0);
    rst = 1'b0; exp_hold = 4'b0; cond_pass_i = 1'b0;
    report();
  end

endmodule